// File: doc/BRIEF.md
# Sample Capture to RAM Engine

The engine copies a stream of samples into a word-addressed memory space made of five banks. Software programs a first and a last word address, picks one of four sample sources and a trigger mode, then fires a trigger through a small register bus. Each valid sample from the selected source is written at the current address counter, and the counter then advances. When the last address has been written, the engine either stops or, in periodic mode, wraps back to the first address.

In one-shot mode a trigger starts the capture at once. In periodic mode the same region is refilled without end until the engine is disabled. In event mode a trigger only arms the engine, and the capture begins on the next external event. An optional end marker makes the write at the last address store zero instead of the sample. The capture port has write priority over the memory: there is no stall and no arbitration. The 13-bit word address is split into a bank select and a 10-bit address within the bank. The top bank is shorter than the others, and addresses above it produce no write.

Top module: `smpl_cap_engine`

## Requirements
- R1: After reset the configuration, first address, last address and status read as 0, and no bank write enable is asserted.
- R2: Register offsets: 0x00 config (bit0 enable, bits[2:1] source, bits[4:3] mode, bit5 end marker), 0x04 first address and 0x08 last address (13 bits each, upper bits read 0), 0x0C status, 0x10 trigger (reads 0). Unmapped offsets read 0.
- R3: Only the source chosen by config bits[2:1] (0..3 = sample port 0..3) is captured. A valid strobe on any other port causes no write and does not move the counter.
- R4: One-shot mode (mode 0; mode 3 behaves the same): a trigger loads the counter with the first address. Each valid sample is written at the counter, and the counter then increments. After the last address is written, running clears, the counter holds the last address, and further samples cause no write.
- R5: Periodic mode (mode 1): after the last address is written, the counter reloads the first address and running stays set.
- R6: Event mode (mode 2): a trigger arms the engine without setting running and without writing. The next cycle with event_i high starts the capture at the first address, which then ends as in one-shot mode.
- R7: With config bit5 set, the write at the last address stores all zeros. Every other address stores the sample value.
- R8: A trigger (a write of 1 to bit0 at 0x10) is ignored while running, while armed, or while the engine is disabled. A write of 0 to the trigger has no effect.
- R9: Writing config with bit0 = 0 stops a capture in the same clock edge, clears running and discards a pending arm. Later samples and events have no effect until a new trigger.
- R10: Word address A goes to bank A/1024 (one-hot mem_we_o bit) at local address A mod 1024. Bank 4 covers only words 4096..4479. At or above 4480 no write enable is asserted, but the counter still advances.
- R11: Status bit0 is running, bits[27:16] hold the low 12 bits of the address counter, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 5 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| smp_data_i | input | 4*DW | Sample data, port n at bits [n*DW +: DW] |
| smp_valid_i | input | 4 | Valid strobe per sample port |
| event_i | input | 1 | External start event for event mode |
| mem_we_o | output | NBANK | Per-bank write enable, at most one set |
| mem_addr_o | output | BANK_AW | Word address within the bank |
| mem_wdata_o | output | DW | Write data |

## Verification
The assertions check on every cycle that at most one bank is enabled, that nothing is written beyond the last mapped word, and that any write comes from the selected source. They also check that the end marker writes zero, that a disable stops the engine at the next edge, that a stop or a wrap follows the last-address write, and that a trigger during a capture leaves the counter alone. Only the bench scenarios can show the complete address sequences per mode, the arm-then-event ordering, the discarded arm, and the register readback and status encoding. A full sweep across all 4501 addresses checks the bank split, including the short top bank.

// File: rtl/smpl_cap_pkg.sv
`timescale 1ns/1ps
package smpl_cap_pkg;
  localparam int NSRC = 4;

  localparam logic [4:0] OFS_CFG   = 5'h00;
  localparam logic [4:0] OFS_FIRST = 5'h04;
  localparam logic [4:0] OFS_LAST  = 5'h08;
  localparam logic [4:0] OFS_STAT  = 5'h0C;
  localparam logic [4:0] OFS_TRIG  = 5'h10;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_EVENT    = 2'd2,
    MODE_RSVD     = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } cap_state_e;

  // packed MSB first: matches config bit layout [5:0]
  typedef struct packed {
    logic       last_zero;
    trig_mode_e mode;
    logic [1:0] src;
    logic       en;
  } cap_cfg_t;
endpackage

// File: rtl/cap_regs.sv
`timescale 1ns/1ps
module cap_regs
  import smpl_cap_pkg::*;
#(
  parameter int AW = 13,
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [4:0]    addr_i,
  input  logic          we_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output cap_cfg_t      cfg_o,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] last_o,
  output logic          trig_o,
  output logic          abort_o,
  input  logic          running_i,
  input  logic [AW-1:0] cnt_i
);
  localparam int CFGW = $bits(cap_cfg_t);

  cap_cfg_t      cfg_q;
  logic [AW-1:0] first_q, last_q;
  logic          unused_bits;

  assign unused_bits = ^{wdata_i[31:AW], cnt_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_CFG:   cfg_q   <= cap_cfg_t'(wdata_i[CFGW-1:0]);
        OFS_FIRST: first_q <= wdata_i[AW-1:0];
        OFS_LAST:  last_q  <= wdata_i[AW-1:0];
        default: ;
      endcase
    end
  end

  assign trig_o  = we_i && (addr_i == OFS_TRIG) && wdata_i[0];
  assign abort_o = we_i && (addr_i == OFS_CFG) && !wdata_i[0];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CFG:   rdata_o[CFGW-1:0] = cfg_q;
      OFS_FIRST: rdata_o[AW-1:0]   = first_q;
      OFS_LAST:  rdata_o[AW-1:0]   = last_q;
      OFS_STAT: begin
        rdata_o[0]       = running_i;
        rdata_o[16 +: CW] = cnt_i[CW-1:0];
      end
      default: ;
    endcase
  end

  assign cfg_o   = cfg_q;
  assign first_o = first_q;
  assign last_o  = last_q;
endmodule

// File: rtl/cap_ctrl.sv
`timescale 1ns/1ps
module cap_ctrl
  import smpl_cap_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cap_cfg_t      cfg_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  input  logic          trig_i,
  input  logic          abort_i,
  input  logic          event_i,
  input  logic          valid_i,
  output logic          running_o,
  output logic [AW-1:0] cnt_o,
  output logic          wr_o,
  output logic          at_last_o
);
  cap_state_e    state_q;
  logic [AW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (abort_i || !cfg_i.en) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (trig_i) begin
          if (cfg_i.mode == MODE_EVENT) begin
            state_q <= ST_ARMED;
          end else begin
            state_q <= ST_RUN;
            cnt_q   <= first_i;
          end
        end
        ST_ARMED: if (event_i) begin
          state_q <= ST_RUN;
          cnt_q   <= first_i;
        end
        ST_RUN: if (valid_i) begin
          if (!at_last) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (cfg_i.mode == MODE_PERIODIC) begin
            cnt_q <= first_i;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign running_o = (state_q == ST_RUN);
  assign cnt_o     = cnt_q;
  assign wr_o      = running_o && valid_i;
  assign at_last_o = at_last;

  assert_abort_stops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!running_o && state_q == ST_IDLE));

  assert_single_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && cnt_o == last_i && cfg_i.mode != MODE_PERIODIC && !abort_i) |=> !running_o);

  assert_periodic_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && cnt_o == last_i && cfg_i.mode == MODE_PERIODIC && !abort_i)
    |=> (running_o && cnt_o == $past(first_i)));

  assert_trig_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && trig_i && !valid_i) |=> (running_o && $stable(cnt_o)));

  assert_arm_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED) |-> !wr_o);
endmodule

// File: rtl/cap_bank_dec.sv
`timescale 1ns/1ps
module cap_bank_dec #(
  parameter int AW        = 13,
  parameter int BANK_AW   = 10,
  parameter int NBANK     = 5,
  parameter int TOP_WORDS = 384
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  output logic [NBANK-1:0]   we_o,
  output logic [BANK_AW-1:0] laddr_o
);
  localparam int IDXW  = AW - BANK_AW;
  localparam int LIMIT = (NBANK - 1) * (2 ** BANK_AW) + TOP_WORDS;

  logic [IDXW-1:0] idx;

  assign idx     = addr_i[AW-1:BANK_AW];
  assign laddr_o = addr_i[BANK_AW-1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (b == NBANK - 1) begin : g_top
      assign we_o[b] = wr_i && (idx == IDXW'(b)) &&
                       ({1'b0, laddr_o} < (BANK_AW+1)'(TOP_WORDS));
    end else begin : g_full
      assign we_o[b] = wr_i && (idx == IDXW'(b));
    end
  end

  assert_bank_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_o));

  assert_no_write_past_map_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(addr_i) >= LIMIT) |-> (we_o == '0));
endmodule

// File: rtl/smpl_cap_engine.sv
`timescale 1ns/1ps
module smpl_cap_engine
  import smpl_cap_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 13,
  parameter int CW        = 12,
  parameter int BANK_AW   = 10,
  parameter int NBANK     = 5,
  parameter int TOP_WORDS = 384
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [4:0]           reg_addr_i,
  input  logic                 reg_we_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [NSRC*DW-1:0]   smp_data_i,
  input  logic [NSRC-1:0]      smp_valid_i,
  input  logic                 event_i,
  output logic [NBANK-1:0]     mem_we_o,
  output logic [BANK_AW-1:0]   mem_addr_o,
  output logic [DW-1:0]        mem_wdata_o
);
  cap_cfg_t      cfg;
  logic [AW-1:0] first_addr, last_addr, cnt;
  logic          trig, abort, running, wr, at_last;
  logic          sel_valid;
  logic [DW-1:0] sel_data;

  cap_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .cfg_o(cfg), .first_o(first_addr), .last_o(last_addr),
    .trig_o(trig), .abort_o(abort), .running_i(running), .cnt_i(cnt)
  );

  assign sel_valid = smp_valid_i[cfg.src];
  assign sel_data  = smp_data_i[cfg.src*DW +: DW];

  cap_ctrl #(.AW(AW)) u_ctrl (
    .clk_i, .rst_ni,
    .cfg_i(cfg), .first_i(first_addr), .last_i(last_addr),
    .trig_i(trig), .abort_i(abort), .event_i, .valid_i(sel_valid),
    .running_o(running), .cnt_o(cnt), .wr_o(wr), .at_last_o(at_last)
  );

  cap_bank_dec #(.AW(AW), .BANK_AW(BANK_AW), .NBANK(NBANK), .TOP_WORDS(TOP_WORDS)) u_dec (
    .clk_i, .rst_ni,
    .wr_i(wr), .addr_i(cnt), .we_o(mem_we_o), .laddr_o(mem_addr_o)
  );

  assign mem_wdata_o = (cfg.last_zero && at_last) ? '0 : sel_data;

  assert_end_marker_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|mem_we_o) && cfg.last_zero && cnt == last_addr) |-> (mem_wdata_o == '0));

  assert_src_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mem_we_o) |-> smp_valid_i[cfg.src]);
endmodule

// File: tb/smpl_cap_engine_test.sv
`timescale 1ns/1ps
module smpl_cap_engine_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [4*DW-1:0] smp_data = '0;
  logic [3:0]    smp_valid = '0;
  logic          ev = 1'b0;
  logic [4:0]    mem_we;
  logic [9:0]    mem_addr;
  logic [DW-1:0] mem_wdata;

  logic [4:0]    g_we;
  logic [9:0]    g_addr;
  logic [DW-1:0] g_data;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  smpl_cap_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .smp_data_i(smp_data), .smp_valid_i(smp_valid), .event_i(ev),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic smp(input int src, input logic [DW-1:0] d);
    @(negedge clk);
    smp_valid = 4'b0001 << src;
    smp_data[src*DW +: DW] = d;
    #1;
    g_we = mem_we; g_addr = mem_addr; g_data = mem_wdata;
    @(posedge clk); #1;
    smp_valid = '0;
  endtask

  task automatic pulse_event();
    @(negedge clk);
    ev = 1'b1;
    @(posedge clk); #1;
    ev = 1'b0;
  endtask

  task automatic exp_wr(input int a, input logic [DW-1:0] d, input string tag);
    if (a < 4480) begin
      chk(g_we == (5'b00001 << (a / 1024)), {tag, " bank"}, g_we, 5'b00001 << (a / 1024));
      chk(g_addr == 10'(a % 1024), {tag, " addr"}, g_addr, a % 1024);
      chk(g_data == d, {tag, " data"}, g_data, d);
    end else begin
      chk(g_we == '0, {tag, " beyond map"}, g_we, 0);
    end
  endtask

  task automatic exp_none(input string tag);
    chk(g_we == '0, tag, g_we, 0);
  endtask

  task automatic stat_is(input logic [31:0] e, input string tag);
    logic [31:0] r;
    reg_rd(5'h0C, r);
    chk(r == e, tag, r, e);
  endtask

  task automatic run_bit_is(input bit e, input string tag);
    logic [31:0] r;
    reg_rd(5'h0C, r);
    chk(r[0] == e, tag, r[0], e);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    reg_rd(5'h00, r); chk(r == 0, "R1 cfg", r, 0);
    reg_rd(5'h04, r); chk(r == 0, "R1 first", r, 0);
    reg_rd(5'h08, r); chk(r == 0, "R1 last", r, 0);
    stat_is(0, "R1 status");
    #1 chk(mem_we == 0, "R1 we", mem_we, 0);

    // R2 register map
    reg_wr(5'h00, 32'hFFFF_FFFF);
    reg_rd(5'h00, r); chk(r == 32'h3F, "R2 cfg readback", r, 32'h3F);
    reg_wr(5'h00, 32'h0);
    reg_wr(5'h04, 32'hFFFF_FFFF);
    reg_rd(5'h04, r); chk(r == 32'h1FFF, "R2 first mask", r, 32'h1FFF);
    reg_wr(5'h08, 32'h0000_0ABC);
    reg_rd(5'h08, r); chk(r == 32'hABC, "R2 last", r, 32'hABC);
    reg_rd(5'h10, r); chk(r == 0, "R2 trig reads 0", r, 0);
    reg_rd(5'h14, r); chk(r == 0, "R2 unmapped", r, 0);

    // R3 R4 R11: one-shot per source
    for (int s = 0; s < 4; s++) begin
      int f = s * 16 + 5;
      reg_wr(5'h00, 32'(1 | (s << 1)));
      reg_wr(5'h04, 32'(f));
      reg_wr(5'h08, 32'(f + 3));
      reg_wr(5'h10, 32'h1);
      stat_is(32'((f << 16) | 1), "R11 status after trigger");
      for (int i = 0; i < 4; i++) begin
        smp((s + 1) % 4, 16'hDEAD);
        exp_none("R3 other source ignored");
        smp(s, 16'((s << 12) | i));
        exp_wr(f + i, 16'((s << 12) | i), "R4 one-shot write");
      end
      stat_is(32'((f + 3) << 16), "R4 stopped, counter holds last");
      smp(s, 16'h1234);
      exp_none("R4 no write after stop");
    end

    // mode 3 behaves as one-shot (R4)
    reg_wr(5'h00, 32'h19);
    reg_wr(5'h04, 32'd7);
    reg_wr(5'h08, 32'd7);
    reg_wr(5'h10, 32'h1);
    smp(0, 16'h0777);
    exp_wr(7, 16'h0777, "R4 mode3 write");
    run_bit_is(0, "R4 mode3 stops");

    // R5 periodic across bank 0/1 border
    reg_wr(5'h00, 32'h0B);
    reg_wr(5'h04, 32'd1023);
    reg_wr(5'h08, 32'd1025);
    reg_wr(5'h10, 32'h1);
    for (int i = 0; i < 7; i++) begin
      smp(1, 16'(16'h5000 + i));
      exp_wr(1023 + (i % 3), 16'(16'h5000 + i), "R5 periodic write");
    end
    stat_is(32'((1024 << 16) | 1), "R5 still running after wraps");

    // R9 abort
    reg_wr(5'h00, 32'h0A);
    run_bit_is(0, "R9 disable clears running");
    reg_wr(5'h00, 32'h0B);
    smp(1, 16'h0BAD);
    exp_none("R9 no write after abort");

    // R6 event mode
    reg_wr(5'h00, 32'h11);
    reg_wr(5'h04, 32'd2047);
    reg_wr(5'h08, 32'd2048);
    reg_wr(5'h10, 32'h1);
    run_bit_is(0, "R6 armed not running");
    smp(0, 16'h6666);
    exp_none("R6 armed no write");
    pulse_event();
    stat_is(32'((2047 << 16) | 1), "R6 event starts at first");
    smp(0, 16'h6001);
    exp_wr(2047, 16'h6001, "R6 write first");
    smp(0, 16'h6002);
    exp_wr(2048, 16'h6002, "R6 write last");
    run_bit_is(0, "R6 stops after last");

    // R9 discard pending arm
    reg_wr(5'h10, 32'h1);
    reg_wr(5'h00, 32'h10);
    reg_wr(5'h00, 32'h11);
    pulse_event();
    run_bit_is(0, "R9 arm discarded");
    smp(0, 16'h0BAD);
    exp_none("R9 no write after discarded arm");

    // R7 end marker
    reg_wr(5'h00, 32'h21);
    reg_wr(5'h04, 32'd50);
    reg_wr(5'h08, 32'd52);
    reg_wr(5'h10, 32'h1);
    for (int i = 0; i < 3; i++) begin
      smp(0, 16'(16'hAAA0 + i));
      exp_wr(50 + i, (i == 2) ? 16'h0 : 16'(16'hAAA0 + i), "R7 end marker");
    end

    // R8 trigger handling
    reg_wr(5'h00, 32'h01);
    reg_wr(5'h04, 32'd10);
    reg_wr(5'h08, 32'd20);
    reg_wr(5'h10, 32'h1);
    smp(0, 16'h0010); exp_wr(10, 16'h0010, "R8 pre");
    smp(0, 16'h0011); exp_wr(11, 16'h0011, "R8 pre");
    reg_wr(5'h10, 32'h1);
    stat_is(32'((12 << 16) | 1), "R8 trigger while running ignored");
    smp(0, 16'h0012); exp_wr(12, 16'h0012, "R8 continues");
    reg_wr(5'h00, 32'h00);
    reg_wr(5'h10, 32'h1);
    reg_wr(5'h00, 32'h01);
    run_bit_is(0, "R8 trigger while disabled ignored");
    reg_wr(5'h10, 32'h0);
    run_bit_is(0, "R8 trigger zero no effect");
    reg_wr(5'h00, 32'h11);
    reg_wr(5'h10, 32'h1);
    reg_wr(5'h10, 32'h1);
    run_bit_is(0, "R8 trigger while armed ignored");
    reg_wr(5'h00, 32'h00);

    // R10 full sweep of the address space
    reg_wr(5'h00, 32'h07);
    reg_wr(5'h04, 32'd0);
    reg_wr(5'h08, 32'd4500);
    reg_wr(5'h10, 32'h1);
    for (int a = 0; a <= 4500; a++) begin
      smp(3, 16'(a) ^ 16'h5A5A);
      exp_wr(a, 16'(a) ^ 16'h5A5A, "R10 sweep");
      if (a == 4099) stat_is(32'((4 << 16) | 1), "R11 counter low 12 bits");
    end
    run_bit_is(0, "R10 sweep ends");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule